// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous burst memory. On a rising clock edge, either of two address strobes captures an external address. One strobe comes from the processor side and the other from the controller side. After the capture, the block generates later addresses of the burst itself. It steps the two lowest address bits on each cycle in which the advance input is high. The upper address bits keep their captured value for the whole burst.

A per-burst ordering input picks the sequence. Linear order wraps modulo four from the starting word. Interleaved order XORs the starting word with the burst position. Interleaved order is chosen when the ordering input is held low, which is the default tie-off. The ordering input is captured together with the address.

Bursting is optional. A strobe on every cycle loads a fresh address each time, with no lost cycle. The outputs are the full current address, the burst position and a flag. The flag reads high once any address has been loaded since reset.

The controller has two named states. ST_IDLE means no address has been held since reset. ST_BURST means an address is held. The transitions are:
- T_LOAD: ST_IDLE to ST_BURST, taken on a strobe.
- T_RELOAD: ST_BURST to ST_BURST, taken on a strobe.
- T_STEP: ST_BURST to ST_BURST, taken on advance without a strobe.
- T_HOLD: stays in the same state when neither strobe nor advance is high.
- T_CLEAR: any state to ST_IDLE, taken on reset.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset clears `addr_out` to 0, `burst_pos` to 0 and `burst_active` to 0 after the clock edge.
- R2: If `strobe_cpu` or `strobe_ctl` is 1 at an edge, then after that edge `addr_out` equals the sampled `addr_in`, `burst_pos` is 0 and `burst_active` is 1.
- R3: With both strobes and `adv` at 0, `addr_out`, `burst_pos` and `burst_active` keep their values across the edge.
- R4: With `burst_active` = 1, no strobe and `adv` = 1, `burst_pos` increases by one modulo 4 after the edge.
- R5: When `order_lin` was 1 at the load edge, the two low bits of `addr_out` equal (loaded low bits + `burst_pos`) mod 4, for example 1,2,3,0.
- R6: When `order_lin` was 0 at the load edge, the two low bits of `addr_out` equal the loaded low bits XOR `burst_pos`, for example 1,0,3,2.
- R7: Between loads, bits above bit 1 of `addr_out` never change.
- R8: If a strobe and `adv` are both 1 at the same edge, the load takes effect and `burst_pos` becomes 0.
- R9: While `burst_active` = 0, `adv` has no effect: `addr_out` and `burst_pos` stay 0.
- R10: Changing `order_lin` in a cycle without a strobe does not alter the sequence of the current burst.
- R11: Strobes on consecutive edges each load their own address, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_cpu | input | 1 | Processor-side address strobe |
| strobe_ctl | input | 1 | Controller-side address strobe |
| adv | input | 1 | Step the burst by one word |
| order_lin | input | 1 | 1 selects linear order, 0 selects interleaved order; captured at load |
| addr_in | input | ADDR_W | External address |
| addr_out | output | ADDR_W | Current word address |
| burst_pos | output | 2 | Position within the burst |
| burst_active | output | 1 | An address is held (state ST_BURST) |

## Verification
The case hardest to reach from the ports is a burst that wraps past its fourth word. In that case the ordering input toggles mid-burst, and an advance coincides with a strobe on the same edge. Random stimulus seldom keeps advance high long enough for this to occur. Directed sequences therefore first run five advances under each order with the ordering input toggled between steps. They then apply a strobe with advance, and back-to-back strobes. After these, a seeded random phase runs with a low strobe rate, so that long advance runs occur.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int unsigned POS_W = 2;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic load;
        logic step;
    } seq_cmd_t;

endpackage

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     strobe_any,
    input  logic     adv,
    output seq_cmd_t cmd,
    output logic     active
);

    seq_state_t state_q;
    seq_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cmd.load = 1'b0;
        cmd.step = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (strobe_any) begin
                    cmd.load = 1'b1;
                    state_d  = ST_BURST;
                end
            end
            ST_BURST: begin
                if (strobe_any) begin
                    cmd.load = 1'b1;
                end else if (adv) begin
                    cmd.step = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign active = (state_q == ST_BURST);

endmodule

// File: rtl/burst_seq_count.sv
module burst_seq_count
    import burst_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_cmd_t          cmd,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              order_lin,
    output logic [ADDR_W-1:0] base_q,
    output logic [POS_W-1:0]  pos_q,
    output logic              lin_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            pos_q  <= '0;
            lin_q  <= 1'b0;
        end else if (cmd.load) begin
            base_q <= addr_in;
            pos_q  <= '0;
            lin_q  <= order_lin;
        end else if (cmd.step) begin
            pos_q  <= pos_q + POS_W'(1);
        end
    end

endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map
    import burst_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [POS_W-1:0]  pos,
    input  logic              lin,
    output logic [ADDR_W-1:0] addr
);

    logic [POS_W-1:0] low_lin;
    logic [POS_W-1:0] low_xor;

    assign low_lin = base[POS_W-1:0] + pos;
    assign low_xor = base[POS_W-1:0] ^ pos;

    generate
        if (ADDR_W > POS_W) begin : g_upper
            assign addr = {base[ADDR_W-1:POS_W], (lin ? low_lin : low_xor)};
        end else begin : g_low_only
            assign addr = lin ? low_lin : low_xor;
        end
    endgenerate

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_cpu,
    input  logic              strobe_ctl,
    input  logic              adv,
    input  logic              order_lin,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        burst_pos,
    output logic              burst_active
);

    seq_cmd_t          cmd;
    logic [ADDR_W-1:0] base_q;
    logic [POS_W-1:0]  pos_q;
    logic              lin_q;
    logic              strobe_any;

    assign strobe_any = strobe_cpu | strobe_ctl;

    burst_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .strobe_any (strobe_any),
        .adv        (adv),
        .cmd        (cmd),
        .active     (burst_active)
    );

    burst_seq_count #(.ADDR_W(ADDR_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .addr_in   (addr_in),
        .order_lin (order_lin),
        .base_q    (base_q),
        .pos_q     (pos_q),
        .lin_q     (lin_q)
    );

    burst_seq_map #(.ADDR_W(ADDR_W)) u_map (
        .base (base_q),
        .pos  (pos_q),
        .lin  (lin_q),
        .addr (addr_out)
    );

    assign burst_pos = pos_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int unsigned ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              strobe_cpu,
    input logic              strobe_ctl,
    input logic              adv,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic [1:0]        burst_pos,
    input logic              burst_active
);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (addr_out == '0 && burst_pos == 2'd0 && !burst_active));

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (strobe_cpu || strobe_ctl) |=>
            (addr_out == $past(addr_in) && burst_pos == 2'd0 && burst_active));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!strobe_cpu && !strobe_ctl && !adv) |=>
            ($stable(addr_out) && $stable(burst_pos) && $stable(burst_active)));

    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (burst_active && adv && !strobe_cpu && !strobe_ctl) |=>
            (burst_pos == $past(burst_pos) + 2'd1));

    p_upper_r7: assert property (@(posedge clk) disable iff (rst)
        (!strobe_cpu && !strobe_ctl) |=>
            (addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])));

    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!burst_active && !strobe_cpu && !strobe_ctl) |=>
            (!burst_active && burst_pos == 2'd0));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .strobe_cpu   (strobe_cpu),
    .strobe_ctl   (strobe_ctl),
    .adv          (adv),
    .addr_in      (addr_in),
    .addr_out     (addr_out),
    .burst_pos    (burst_pos),
    .burst_active (burst_active)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

    localparam int unsigned ADDR_W = 20;
    localparam time CLK_P = 10ns;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              strobe_cpu = 1'b0;
    logic              strobe_ctl = 1'b0;
    logic              adv = 1'b0;
    logic              order_lin = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [ADDR_W-1:0] addr_out;
    logic [1:0]        burst_pos;
    logic              burst_active;

    int n_vec = 0;
    int n_bad = 0;

    logic [ADDR_W-1:0] m_base = '0;
    logic [1:0]        m_pos = '0;
    logic              m_lin = 1'b0;
    logic              m_act = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W)) u_burst_addr_seq (
        .clk          (clk),
        .rst          (rst),
        .strobe_cpu   (strobe_cpu),
        .strobe_ctl   (strobe_ctl),
        .adv          (adv),
        .order_lin    (order_lin),
        .addr_in      (addr_in),
        .addr_out     (addr_out),
        .burst_pos    (burst_pos),
        .burst_active (burst_active)
    );

    function automatic logic [ADDR_W-1:0] exp_addr();
        logic [1:0] lo;
        lo = m_lin ? (m_base[1:0] + m_pos) : (m_base[1:0] ^ m_pos);
        return {m_base[ADDR_W-1:2], lo};
    endfunction

    task automatic check(input string tag);
        n_vec++;
        if (addr_out !== exp_addr() || burst_pos !== m_pos || burst_active !== m_act) begin
            n_bad++;
            $display("FAIL %s: addr=%h pos=%0d act=%b expected addr=%h pos=%0d act=%b",
                     tag, addr_out, burst_pos, burst_active, exp_addr(), m_pos, m_act);
        end
    endtask

    task automatic step(input logic r, input logic sc, input logic sk, input logic a,
                        input logic ol, input logic [ADDR_W-1:0] ad, input string tag);
        rst = r; strobe_cpu = sc; strobe_ctl = sk; adv = a; order_lin = ol; addr_in = ad;
        @(posedge clk);
        if (r) begin
            m_base = '0; m_pos = '0; m_lin = 1'b0; m_act = 1'b0;
        end else if (sc || sk) begin
            m_base = ad; m_pos = '0; m_lin = ol; m_act = 1'b1;
        end else if (a && m_act) begin
            m_pos = m_pos + 2'd1;
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(1, 0, 0, 0, 0, 20'hABCDE, "R1 reset");
        step(0, 0, 0, 1, 1, 20'h12345, "R9 adv idle");
        step(0, 0, 0, 1, 0, 20'h12345, "R9 adv idle again");
        // linear burst from low bits 1, order toggled mid-burst
        step(0, 1, 0, 0, 1, 20'h5A5A1, "R2 load cpu strobe");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, i[0], 20'h0, "R5 R10 linear step");
        step(0, 0, 0, 0, 0, 20'hFFFFF, "R3 hold");
        // interleaved burst from low bits 1
        step(0, 0, 1, 0, 0, 20'h0F0F1, "R2 load ctl strobe");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, ~i[0], 20'h0, "R6 R7 R10 interleaved step");
        step(0, 1, 0, 1, 1, 20'h33332, "R8 strobe with adv");
        step(0, 0, 1, 1, 0, 20'h44443, "R8 R11 back-to-back");
        step(0, 1, 1, 0, 1, 20'h55550, "R11 back-to-back both strobes");
        step(0, 0, 0, 1, 0, 20'h0, "R4 step after load");
        step(1, 0, 0, 0, 0, 20'h0, "R1 reset mid-burst");
        void'($urandom(32'd2024));
        for (int i = 0; i < 2000; i++) begin
            logic r, sc, sk, a, ol;
            r  = ($urandom % 100) < 1;
            sc = ($urandom % 100) < 8;
            sk = ($urandom % 100) < 8;
            a  = ($urandom % 100) < 75;
            ol = $urandom % 2;
            step(r, sc, sk, a, ol, ADDR_W'($urandom), "R3 R4 R5 R6 R7 random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule